// File: doc/BRIEF.md
# Addressed SPI Register Access Slave

This block is the serial front end of a small byte-addressed register file. It sits on an SPI bus in mode 0, most significant bit first, and up to eight identical slaves may share one chip select. Every frame opens with a command byte whose upper nibble is a fixed family code. Three bits of that byte pick one slave and its lowest bit picks the direction. The next byte is the starting register address, and any number of data bytes follow. The block turns each completed data byte into a one-cycle write strobe, or a one-cycle read strobe, toward an external register file. For reads it shifts the returned bytes out on MISO.

The block keeps one configuration byte of its own. Bit 3 turns on matching of the command's slave-select bits against the strap pins. Bit 5 freezes the register pointer, so that repeated bytes hit the same address. When this bit is clear the pointer advances after every byte and wraps to zero past the last implemented address. A build-time option selects a paired-bank layout. In that layout each logical register occupies two adjacent byte addresses, and the configuration byte answers at both of its addresses. All SPI inputs are brought into the system clock domain through a synchronizer, so SCK must be slow relative to the system clock.

Top module: `spi_addr_regslave`

## Requirements
- R1: A frame is accepted only if the first byte has the upper nibble 4'b0100. Bits [3:1] of that byte select the slave and bit 0 chooses the direction (1 = read, 0 = write). Any other upper nibble makes the slave ignore the rest of the frame.
- R2: When configuration bit 3 is 1, bits [3:1] of the command must equal `hw_addr`. When it is 0, they must be 3'b000. A frame that does not match causes no strobe and never raises `spi_miso_oe`.
- R3: In a write frame, the second byte loads the pointer. Each completed data byte then gives exactly one `reg_we` pulse carrying the pointer on `reg_addr` and the byte on `reg_wdata`.
- R4: In a read frame, one `reg_re` pulse fetches each byte, with `reg_rdata` sampled in that same cycle. The first fetch follows the address byte, and each later fetch follows the completion of the previous data byte. Bytes go out MSB first, changing after SCK falls.
- R5: With configuration bit 5 at 0, the pointer advances by one after every data byte. At or beyond the last implemented byte address it goes to 0.
- R6: With configuration bit 5 at 1, the pointer stays fixed. A byte that changes bit 5 still advances the pointer under the old setting.
- R7: The configuration byte lives inside the block. In the flat layout it sits at address CFG_REG. In the paired layout it sits at 2*CFG_REG and 2*CFG_REG+1, and a write to either address updates the single copy. It is read and written without any strobe, resets to 0 and is shown on `cfg_out`.
- R8: A write to an address above the last implemented byte produces no strobe. A read of such an address returns 8'h00 with no strobe.
- R9: Raising chip select ends the frame and discards a partial byte without a strobe. The next frame starts again at the command byte.
- R10: `spi_miso_oe` is high only in the data phase of a selected read frame.
- R11: `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Shared chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, valid when enabled |
| spi_miso_oe | output | 1 | Output enable for the MISO driver |
| hw_addr | input | 3 | Strap value for slave selection |
| reg_addr | output | AW | Byte address of the strobe |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_re | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data, sampled while reg_re is high |
| cfg_out | output | 8 | Current configuration byte |

## Verification
Writing the configuration byte and advancing the pointer can happen in the same byte-completion cycle. In that case the pointer must step under the old sequencing bit. The bench provokes this with a two-byte write frame in the paired build. The frame's first byte sets the freeze bit at the upper copy of the configuration address. The scoreboard then requires the second byte to land one address higher, and every later byte to stay put. A second collision is between prefetching the next read byte and the master's last clock edge. The bench judges it by the exact address sequence of read strobes that it queues before each frame.

// File: rtl/spi_addr_regslave_pkg.sv
package spi_addr_regslave_pkg;
   typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA, PH_SKIP} phase_e;
   localparam logic [3:0] OP_FAMILY    = 4'b0100;
   localparam int         CFG_SEQ_BIT  = 5;
   localparam int         CFG_HWA_BIT  = 3;
   localparam int         BYTE_W       = 8;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial assert (STAGES >= 2) else $fatal(1, "sar_sync needs two stages or more");

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [WIDTH-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RESET_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RESET_VAL;
            else        r <= g_stg[i-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/sar_rx_framer.sv
module sar_rx_framer
   import spi_addr_regslave_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              sck_fall,
   output logic              bit_idle
);
   localparam int CW = $clog2(BYTE_W);

   logic              sck_d;
   logic              sck_rise;
   logic [CW-1:0]     cnt_q;
   logic [BYTE_W-2:0] sh_q;

   assign sck_rise  = sck_s & ~sck_d & ~cs_n_s;
   assign sck_fall  = ~sck_s & sck_d & ~cs_n_s;
   assign bit_idle  = (cnt_q == '0);
   assign byte_done = sck_rise && (cnt_q == CW'(BYTE_W-1));
   assign rx_byte   = {sh_q, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cnt_q <= '0;
         sh_q  <= '0;
      end else begin
         sck_d <= sck_s;
         if (cs_n_s) begin
            cnt_q <= '0;
         end else if (sck_rise) begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= {sh_q[BYTE_W-3:0], mosi_s};
         end
      end
   end
endmodule

// File: rtl/sar_tx_shift.sv
module sar_tx_shift
   import spi_addr_regslave_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              shift,
   output logic              bit_out
);
   logic [BYTE_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= '0;
      else if (clear) sh_q <= '0;
      else if (load)  sh_q <= load_val;
      else if (shift) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
   end

   assign bit_out = sh_q[BYTE_W-1];
endmodule

// File: rtl/spi_addr_regslave.sv
module spi_addr_regslave
   import spi_addr_regslave_pkg::*;
#(
   parameter int LOG_REGS    = 11,
   parameter int CFG_REG     = 5,
   parameter bit PAIRED      = 1'b0,
   parameter int SYNC_STAGES = 2,
   localparam int NBYTES     = PAIRED ? 2*LOG_REGS : LOG_REGS,
   localparam int AW         = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spi_sck,
   input  logic          spi_cs_n,
   input  logic          spi_mosi,
   output logic          spi_miso,
   output logic          spi_miso_oe,
   input  logic [2:0]    hw_addr,
   output logic [AW-1:0] reg_addr,
   output logic [7:0]    reg_wdata,
   output logic          reg_we,
   output logic          reg_re,
   input  logic [7:0]    reg_rdata,
   output logic [7:0]    cfg_out
);
   localparam logic [7:0] LAST = 8'(NBYTES-1);

   initial assert (NBYTES >= 2 && NBYTES <= 256) else $fatal(1, "byte space must be 2..256");
   initial assert (CFG_REG >= 0 && CFG_REG < LOG_REGS) else $fatal(1, "CFG_REG outside register space");

   // input synchronization
   logic sck_s, cs_n_s, mosi_s;
   sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sck, spi_cs_n, spi_mosi}),
      .q     ({sck_s, cs_n_s, mosi_s})
   );

   // bit framing
   logic       byte_done, sck_fall, bit_idle;
   logic [7:0] rx_byte;
   sar_rx_framer u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .cs_n_s    (cs_n_s),
      .mosi_s    (mosi_s),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .sck_fall  (sck_fall),
      .bit_idle  (bit_idle)
   );

   // frame state
   phase_e        phase_q;
   logic          rd_q;
   logic [7:0]    ptr_q;
   logic [7:0]    cfg_q;
   logic [7:0]    pend_q;
   logic          we_q, re_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    wdata_q;

   // target address for the current byte event
   logic [7:0] tgt, tgt_next;
   logic       tgt_cfg, tgt_ok, op_match, seq_fixed;
   logic [2:0] want_sel;

   assign tgt       = (phase_q == PH_ADDR) ? rx_byte : ptr_q;
   assign tgt_ok    = (tgt <= LAST);
   assign seq_fixed = cfg_q[CFG_SEQ_BIT];
   assign tgt_next  = seq_fixed ? tgt : ((tgt >= LAST) ? 8'h00 : tgt + 8'd1);
   assign want_sel  = cfg_q[CFG_HWA_BIT] ? hw_addr : 3'b000;
   assign op_match  = (rx_byte[7:4] == OP_FAMILY) && (rx_byte[3:1] == want_sel);

   if (PAIRED) begin : g_paired
      assign tgt_cfg = (tgt[7:1] == 7'(CFG_REG));
   end else begin : g_flat
      assign tgt_cfg = (tgt == 8'(CFG_REG));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OP;
         rd_q    <= 1'b0;
         ptr_q   <= '0;
         cfg_q   <= '0;
         pend_q  <= '0;
         we_q    <= 1'b0;
         re_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         we_q <= 1'b0;
         re_q <= 1'b0;
         if (re_q) pend_q <= reg_rdata;
         if (cs_n_s) begin
            phase_q <= PH_OP;
         end else if (byte_done) begin
            unique case (phase_q)
               PH_OP: begin
                  if (op_match) begin
                     phase_q <= PH_ADDR;
                     rd_q    <= rx_byte[0];
                  end else begin
                     phase_q <= PH_SKIP;
                  end
               end
               PH_ADDR, PH_DATA: begin
                  phase_q <= PH_DATA;
                  if (rd_q || phase_q == PH_DATA) ptr_q <= tgt_next;
                  else                            ptr_q <= tgt;
                  if (rd_q) begin
                     if (tgt_cfg) begin
                        pend_q <= cfg_q;
                     end else if (tgt_ok) begin
                        re_q   <= 1'b1;
                        addr_q <= tgt[AW-1:0];
                     end else begin
                        pend_q <= 8'h00;
                     end
                  end else if (phase_q == PH_DATA) begin
                     if (tgt_cfg) begin
                        cfg_q <= rx_byte;
                     end else if (tgt_ok) begin
                        we_q    <= 1'b1;
                        addr_q  <= tgt[AW-1:0];
                        wdata_q <= rx_byte;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // serial output
   logic rd_active, in_skip, tx_bit;
   assign rd_active = (phase_q == PH_DATA) && rd_q;
   assign in_skip   = (phase_q == PH_SKIP);

   sar_tx_shift u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cs_n_s),
      .load     (sck_fall && bit_idle && rd_active),
      .load_val (pend_q),
      .shift    (sck_fall && !bit_idle),
      .bit_out  (tx_bit)
   );

   assign spi_miso_oe = rd_active && !cs_n_s;
   assign spi_miso    = spi_miso_oe & tx_bit;
   assign reg_we      = we_q;
   assign reg_re      = re_q;
   assign reg_addr    = addr_q;
   assign reg_wdata   = wdata_q;
   assign cfg_out     = cfg_q;
endmodule

// File: rtl/spi_addr_regslave_chk.sv
module spi_addr_regslave_chk #(
   parameter int AW = 4,
   parameter logic [7:0] LAST = 8'd10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic          reg_re,
   input logic [AW-1:0] reg_addr,
   input logic [7:0]    cfg_out,
   input logic          in_skip
);
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re)); // R11

   AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      in_skip |=> !(reg_we || reg_re)); // R2

   AST_CFG_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_out) |-> !(reg_we || reg_re)); // R7

   AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (8'(reg_addr) <= LAST)); // R8

   AST_RE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |-> (8'(reg_addr) <= LAST)); // R8
endmodule

bind spi_addr_regslave spi_addr_regslave_chk #(.AW(AW), .LAST(LAST)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_re   (reg_re),
   .reg_addr (reg_addr),
   .cfg_out  (cfg_out),
   .in_skip  (in_skip)
);

// File: tb/tb_spi_addr_regslave.sv
module tb_spi_addr_regslave;
   localparam int NB   = 22;
   localparam int AW   = 5;
   localparam int HALF = 8;

   typedef struct packed {logic wr; logic [7:0] addr; logic [7:0] data;} item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso, spi_miso_oe, reg_we, reg_re;
   logic [AW-1:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata, cfg_out;
   logic [2:0] hw_addr = 3'b101;

   always #5 clk = ~clk;

   spi_addr_regslave #(.LOG_REGS(11), .CFG_REG(5), .PAIRED(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .hw_addr(hw_addr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .cfg_out(cfg_out)
   );

   logic [7:0] mem [NB];
   logic [7:0] exp_mem [NB];
   logic [7:0] wbuf [4];
   logic [7:0] rbuf [4];
   item_t expq [$];
   int checks = 0, errors = 0, unexp = 0;
   bit oe_seen = 0, finished = 0;

   assign reg_rdata = mem[reg_addr];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (spi_miso_oe) oe_seen = 1'b1;
         if (reg_we && reg_re) check(1'b0, "R11", 32'h3, 32'h1);
         if (reg_we) mem[reg_addr] = reg_wdata;
         if (reg_we || reg_re) begin
            if (expq.size() == 0) begin
               unexp++;
               check(1'b0, "R3/R4 unexpected strobe", {23'd0, reg_we, 8'(reg_addr)}, 32'h0);
            end else begin
               item_t it;
               it = expq.pop_front();
               check(it.wr == reg_we, "R3/R4 strobe kind", 32'(reg_we), 32'(it.wr));
               check(8'(reg_addr) == it.addr, "R5/R6 strobe address", 32'(reg_addr), 32'(it.addr));
               if (it.wr) check(reg_wdata == it.data, "R3 write data", 32'(reg_wdata), 32'(it.data));
            end
         end
      end
   end

   task automatic exp_wr(input logic [7:0] a, input logic [7:0] d);
      expq.push_back({1'b1, a, d});
      exp_mem[a] = d;
   endtask

   task automatic exp_rd(input logic [7:0] a);
      expq.push_back({1'b0, a, 8'h00});
   endtask

   task automatic spi_bit(input logic b, output logic r);
      spi_mosi = b;
      repeat (HALF) @(negedge clk);
      r = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] t, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) spi_bit(t[i], r[i]);
   endtask

   task automatic frame(input logic [7:0] op, input logic [7:0] ad, input int n, input int cut);
      logic [7:0] junk;
      logic jb;
      oe_seen = 1'b0;
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_byte(op, junk);
      spi_byte(ad, junk);
      for (int k = 0; k < n; k++) spi_byte(wbuf[k], rbuf[k]);
      for (int k = 0; k < cut; k++) spi_bit(1'b1, jb);
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (4*HALF) @(negedge clk);
      check(expq.size() == 0, "R3/R4 all expected strobes seen", 32'(expq.size()), 32'h0);
   endtask

   initial begin
      int u0;
      for (int i = 0; i < NB; i++) begin
         mem[i] = 8'hC0 + 8'(i);
         exp_mem[i] = 8'hC0 + 8'(i);
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // reset state
      check(cfg_out == 8'h00, "R7 reset config", 32'(cfg_out), 32'h0);
      check(spi_miso_oe == 1'b0, "R10 reset oe", 32'(spi_miso_oe), 32'h0);
      check(!reg_we && !reg_re, "R3 reset strobes", {reg_we, reg_re}, 32'h0);

      // R3 single write, hardware addressing off, select bits 000
      wbuf[0] = 8'hA5; exp_wr(8'd2, 8'hA5);
      frame(8'h40, 8'd2, 1, 0);
      check(oe_seen == 1'b0, "R10 no oe on write", 32'(oe_seen), 32'h0);

      // R5 sequential write across the top address
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      exp_wr(8'd20, 8'h11); exp_wr(8'd21, 8'h22); exp_wr(8'd0, 8'h33);
      frame(8'h40, 8'd20, 3, 0);

      // R4 sequential read with wrap and prefetch
      exp_rd(8'd20); exp_rd(8'd21); exp_rd(8'd0); exp_rd(8'd1);
      frame(8'h41, 8'd20, 3, 0);
      check(rbuf[0] == exp_mem[20], "R4 read byte 0", 32'(rbuf[0]), 32'(exp_mem[20]));
      check(rbuf[1] == exp_mem[21], "R4 read byte 1", 32'(rbuf[1]), 32'(exp_mem[21]));
      check(rbuf[2] == exp_mem[0], "R5 read after wrap", 32'(rbuf[2]), 32'(exp_mem[0]));
      check(oe_seen == 1'b1, "R10 oe on read", 32'(oe_seen), 32'h1);

      // R2 nonzero select bits with hardware addressing off are ignored
      u0 = unexp;
      wbuf[0] = 8'h77;
      frame(8'h4A, 8'd3, 1, 0);
      frame(8'h4B, 8'd3, 1, 0);
      check(oe_seen == 1'b0, "R2 ignored read keeps oe low", 32'(oe_seen), 32'h0);
      check(unexp == u0, "R2 no strobes when unselected", 32'(unexp), 32'(u0));
      exp_rd(8'd3); exp_rd(8'd4);
      frame(8'h41, 8'd3, 1, 0);
      check(rbuf[0] == exp_mem[3], "R2 ignored write left data", 32'(rbuf[0]), 32'(exp_mem[3]));

      // R7 config write at lower copy, read from upper copy
      wbuf[0] = 8'h08;
      frame(8'h40, 8'd10, 1, 0);
      check(cfg_out == 8'h08, "R7 config written", 32'(cfg_out), 32'h08);
      exp_rd(8'd12);
      frame(8'h4B, 8'd11, 1, 0);
      check(rbuf[0] == 8'h08, "R7 mirrored copy", 32'(rbuf[0]), 32'h08);

      // R2 with hardware addressing on: 000 ignored, strap value accepted
      u0 = unexp;
      wbuf[0] = 8'h66;
      frame(8'h40, 8'd3, 1, 0);
      check(unexp == u0, "R2 mismatch ignored", 32'(unexp), 32'(u0));
      wbuf[0] = 8'h5C; exp_wr(8'd3, 8'h5C);
      frame(8'h4A, 8'd3, 1, 0);

      // R6 freeze set through upper copy; same-byte step uses old setting
      wbuf[0] = 8'h28; wbuf[1] = 8'h5E; exp_wr(8'd12, 8'h5E);
      frame(8'h4A, 8'd11, 2, 0);
      check(cfg_out == 8'h28, "R7 upper copy write", 32'(cfg_out), 32'h28);
      wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
      exp_wr(8'd4, 8'h01); exp_wr(8'd4, 8'h02); exp_wr(8'd4, 8'h03);
      frame(8'h4A, 8'd4, 3, 0);
      exp_rd(8'd4); exp_rd(8'd4); exp_rd(8'd4);
      frame(8'h4B, 8'd4, 2, 0);
      check(rbuf[0] == 8'h03 && rbuf[1] == 8'h03, "R6 fixed-address read",
            {16'd0, rbuf[0], rbuf[1]}, 32'h0303);

      // R9 abort in the middle of a data byte
      frame(8'h4A, 8'd6, 0, 4);
      exp_rd(8'd6); exp_rd(8'd6);
      frame(8'h4B, 8'd6, 1, 0);
      check(rbuf[0] == exp_mem[6], "R9 aborted byte not written", 32'(rbuf[0]), 32'(exp_mem[6]));

      // R1 wrong family code
      u0 = unexp;
      wbuf[0] = 8'h99;
      frame(8'h6A, 8'd7, 1, 0);
      check(unexp == u0, "R1 wrong family ignored", 32'(unexp), 32'(u0));
      exp_rd(8'd7); exp_rd(8'd7);
      frame(8'h4B, 8'd7, 1, 0);
      check(rbuf[0] == exp_mem[7], "R1 data untouched", 32'(rbuf[0]), 32'(exp_mem[7]));

      // R8 out-of-range access
      wbuf[0] = 8'h08;
      frame(8'h4A, 8'd10, 1, 0);
      u0 = unexp;
      wbuf[0] = 8'h44;
      frame(8'h4A, 8'd30, 1, 0);
      check(unexp == u0, "R8 out-of-range write silent", 32'(unexp), 32'(u0));
      exp_rd(8'd0);
      frame(8'h4B, 8'd30, 1, 0);
      check(rbuf[0] == 8'h00, "R8 out-of-range read zero", 32'(rbuf[0]), 32'h0);

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         check(1'b0, "watchdog", 32'h0, 32'h1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule